// File: doc/BRIEF.md
# SAR ADC Conversion and Readout Controller

This block sits on the host side of a 12-bit, two-input successive-approximation converter that has a four-wire serial port. When the user side asks for a sample, the controller raises the conversion strobe. It then waits out the worst-case conversion time, or the typical time if a parameter selects it. Next it lowers the strobe and drives twelve serial clock periods. On those clocks it reads back the result, most significant bit first. On the first six of the same clocks it sends the converter the settings for the following conversion.

Two strobe styles can be chosen per request. In the short style the strobe drops two system clocks after it rises, which is well inside the 40 ns allowed before the first bit decision, and the converter stays powered. In the hold style the strobe stays high until the wait ends, so the converter sleeps and is woken when the strobe falls. Each result is reported with a one-cycle valid pulse. A negative flag goes with it, set only for a bipolar (two's complement) reading whose top bit is one. Pacing logic keeps an acquisition gap after each readout and caps the start rate at one conversion per `CYCLE_CYC` system clocks (500 ksps at 100 MHz by default).

Top module: `sar_adc_host`

## Requirements
- R1: While reset is held, the strobe, serial clock, serial data out, busy and valid outputs are all low.
- R2: A start request seen in idle raises the strobe and busy on the same clock edge. A request made while a conversion runs causes no second strobe rise.
- R3: In the short style (hold input low) the strobe is high for exactly `STRB_CYC` cycles (2 by default, 20 ns). It never falls between that point and the end of the conversion.
- R4: In the hold style the strobe is high for exactly the conversion wait of `CONV_MAX_CYC` cycles (160, 1.6 µs), so the converter is still strobed high when it finishes and goes to sleep.
- R5: The first serial clock rise comes no earlier than the conversion wait after the strobe rise. Exactly 12 serial clock rises occur per conversion.
- R6: The configuration word goes out on the first six serial clock rises in this order: single-ended/differential, odd/sign, select bit 1, select bit 0, unipolar, sleep. The data line is low on rises 7 to 12, and it changes only on a serial clock fall or when the word is first loaded.
- R7: The serial data is sampled on each serial clock rise, and the first bit becomes bit 11 of `sample_o`.
- R8: `negative_o` is 1 only when the unipolar bit of that request was 0 and bit 11 of the sample is 1.
- R9: `valid_o` is high for exactly one cycle once the twelfth bit is in. `busy_o` falls on the edge where `valid_o` rises.
- R10: Between a valid pulse and the next strobe rise there are at least `ACQ_CYC` cycles (24). Two strobe rises are at least `CYCLE_CYC` cycles (200) apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Conversion request, taken when idle |
| cfg_single_i | input | 1 | Single-ended (1) or differential (0) |
| cfg_odd_i | input | 1 | Odd/sign input selection |
| cfg_sel_i | input | 2 | Channel select bits |
| cfg_uni_i | input | 1 | Unipolar (1) or bipolar (0) coding |
| cfg_sleep_i | input | 1 | Sleep bit forwarded to the converter |
| hold_high_i | input | 1 | Keep strobe high through conversion |
| busy_o | output | 1 | Conversion or readout in progress |
| valid_o | output | 1 | One-cycle result strobe |
| sample_o | output | 12 | Last 12-bit result, raw coding |
| negative_o | output | 1 | Result is a negative bipolar value |
| convst_o | output | 1 | Conversion strobe to the converter |
| sck_o | output | 1 | Serial clock to the converter |
| sdi_o | output | 1 | Configuration data to the converter |
| sdo_i | input | 1 | Serial result from the converter |

## Verification
The checker watches several properties on every cycle. Busy rises with the strobe and never overlaps a second rise. The serial clock moves only inside a busy readout with the strobe low. The data line changes only at a serial clock fall or a word load. Valid lasts one cycle and comes exactly when busy drops, with twelve serial rises behind it. The negative flag needs a set top bit, and strobe rises keep the rate spacing. The bench's converter model is needed for the rest: that the received word and its bit order match each request, that the sample matches the value the model served, and that strobe width, sleep entry and acquisition gap differ correctly between the short and hold styles.

// File: rtl/sar_pkg.sv
package sar_pkg;
  localparam int SAMPLE_W = 12;
  localparam int CFG_W    = 6;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CONV,
    ST_SHIFT,
    ST_DONE,
    ST_ACQ
  } ctl_state_t;

  typedef struct packed {
    logic       single;
    logic       odd;
    logic [1:0] sel;
    logic       uni;
    logic       sleep;
    logic       hold;
  } req_cfg_t;

  // Word sent on the first serial rises, first-sent bit in the MSB.
  function automatic logic [CFG_W-1:0] cfg_word(input req_cfg_t c);
    return {c.single, c.odd, c.sel, c.uni, c.sleep};
  endfunction

  // Sign only exists in two's complement coding.
  function automatic logic sample_negative(input logic uni,
                                           input logic [SAMPLE_W-1:0] s);
    return !uni && s[SAMPLE_W-1];
  endfunction
endpackage

// File: rtl/sar_pacer.sv
// Saturating interval counter: ok once PERIOD cycles have passed since kick.
module sar_pacer #(
  parameter int PERIOD = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic kick,
  output logic ok
);
  localparam int W = $clog2(PERIOD + 1);
  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  cnt <= W'(PERIOD);
    else if (kick)               cnt <= W'(1);
    else if (cnt != W'(PERIOD))  cnt <= cnt + W'(1);
  end

  assign ok = (cnt == W'(PERIOD));
endmodule

// File: rtl/sar_serial.sv
// Serial clock engine: HALF system cycles per clock phase, samples on rise,
// advances the outgoing word on fall.
module sar_serial #(
  parameter int HALF     = 2,
  parameter int BITS     = 12,
  parameter int CFG_BITS = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                go,
  input  logic [CFG_BITS-1:0] cfg,
  input  logic                sdo,
  output logic                sck,
  output logic                sdi,
  output logic                done,
  output logic [BITS-1:0]     data
);
  localparam int HW = $clog2(HALF + 1);
  localparam int BW = $clog2(BITS + 1);

  logic                active;
  logic [HW-1:0]       hcnt;
  logic [BW-1:0]       nrise;
  logic [CFG_BITS-1:0] osr;
  logic                phase_end;

  assign phase_end = active && (hcnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      hcnt   <= '0;
      nrise  <= '0;
      osr    <= '0;
      sck    <= 1'b0;
      sdi    <= 1'b0;
      done   <= 1'b0;
      data   <= '0;
    end else begin
      done <= 1'b0;
      if (go) begin
        active <= 1'b1;
        hcnt   <= HW'(HALF - 1);
        nrise  <= '0;
        sck    <= 1'b0;
        sdi    <= cfg[CFG_BITS-1];
        osr    <= {cfg[CFG_BITS-2:0], 1'b0};
      end else if (active) begin
        if (!phase_end) begin
          hcnt <= hcnt - HW'(1);
        end else begin
          hcnt <= HW'(HALF - 1);
          sck  <= !sck;
          if (!sck) begin
            data  <= {data[BITS-2:0], sdo};
            nrise <= nrise + BW'(1);
          end else if (nrise == BW'(BITS)) begin
            active <= 1'b0;
            done   <= 1'b1;
            sdi    <= 1'b0;
          end else begin
            sdi <= osr[CFG_BITS-1];
            osr <= {osr[CFG_BITS-2:0], 1'b0};
          end
        end
      end
    end
  end
endmodule

// File: rtl/sar_adc_host.sv
module sar_adc_host
  import sar_pkg::*;
#(
  parameter int SCK_HALF     = 2,
  parameter int STRB_CYC     = 2,
  parameter int CONV_MAX_CYC = 160,
  parameter int CONV_TYP_CYC = 130,
  parameter bit USE_TYP      = 1'b0,
  parameter int ACQ_CYC      = 24,
  parameter int CYCLE_CYC    = 200
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_i,
  input  logic                cfg_single_i,
  input  logic                cfg_odd_i,
  input  logic [1:0]          cfg_sel_i,
  input  logic                cfg_uni_i,
  input  logic                cfg_sleep_i,
  input  logic                hold_high_i,
  output logic                busy_o,
  output logic                valid_o,
  output logic [SAMPLE_W-1:0] sample_o,
  output logic                negative_o,
  output logic                convst_o,
  output logic                sck_o,
  output logic                sdi_o,
  input  logic                sdo_i
);
  localparam int CONV_CYC = USE_TYP ? CONV_TYP_CYC : CONV_MAX_CYC;
  localparam int CW       = $clog2(CONV_CYC + 1);

  ctl_state_t          state;
  req_cfg_t            cfg_q;
  logic [CW-1:0]       conv_cnt;
  logic                launch;
  logic                serial_go;
  logic                strobe_drop;
  logic                ser_done;
  logic [SAMPLE_W-1:0] ser_data;
  logic                acq_ok;
  logic                pace_ok;
  logic [SAMPLE_W-1:0] sample_q;
  logic                neg_q;
  logic                convst_q;

  // Named events shared with the checker.
  assign launch      = (state == ST_IDLE) && start_i;
  assign serial_go   = (state == ST_CONV) && (conv_cnt == CW'(CONV_CYC - 1));
  assign strobe_drop = (state == ST_CONV) && !cfg_q.hold
                       && (conv_cnt == CW'(STRB_CYC - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      cfg_q    <= '0;
      conv_cnt <= '0;
      convst_q <= 1'b0;
      sample_q <= '0;
      neg_q    <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: if (launch) begin
          state    <= ST_CONV;
          convst_q <= 1'b1;
          conv_cnt <= '0;
          cfg_q    <= '{single: cfg_single_i, odd: cfg_odd_i, sel: cfg_sel_i,
                        uni: cfg_uni_i, sleep: cfg_sleep_i, hold: hold_high_i};
        end
        ST_CONV: begin
          conv_cnt <= conv_cnt + CW'(1);
          if (strobe_drop) convst_q <= 1'b0;
          if (serial_go) begin
            convst_q <= 1'b0;
            state    <= ST_SHIFT;
          end
        end
        ST_SHIFT: if (ser_done) begin
          sample_q <= ser_data;
          neg_q    <= sample_negative(cfg_q.uni, ser_data);
          state    <= ST_DONE;
        end
        ST_DONE: state <= ST_ACQ;
        ST_ACQ:  if (acq_ok && pace_ok) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  sar_serial #(
    .HALF     (SCK_HALF),
    .BITS     (SAMPLE_W),
    .CFG_BITS (CFG_W)
  ) u_serial (
    .clk   (clk),
    .rst_n (rst_n),
    .go    (serial_go),
    .cfg   (cfg_word(cfg_q)),
    .sdo   (sdo_i),
    .sck   (sck_o),
    .sdi   (sdi_o),
    .done  (ser_done),
    .data  (ser_data)
  );

  sar_pacer #(.PERIOD(ACQ_CYC)) u_acq (
    .clk   (clk),
    .rst_n (rst_n),
    .kick  (state == ST_DONE),
    .ok    (acq_ok)
  );

  sar_pacer #(.PERIOD(CYCLE_CYC)) u_rate (
    .clk   (clk),
    .rst_n (rst_n),
    .kick  (launch),
    .ok    (pace_ok)
  );

  assign busy_o     = (state == ST_CONV) || (state == ST_SHIFT);
  assign valid_o    = (state == ST_DONE);
  assign sample_o   = sample_q;
  assign negative_o = neg_q;
  assign convst_o   = convst_q;
endmodule

// File: rtl/sar_adc_host_chk.sv
module sar_adc_host_chk #(
  parameter int CYCLE_CYC = 200,
  parameter int BITS      = 12
) (
  input logic clk,
  input logic rst_n,
  input logic busy_o,
  input logic valid_o,
  input logic convst_o,
  input logic sck_o,
  input logic sdi_o,
  input logic sample_msb,
  input logic negative_o,
  input logic serial_go
);
  localparam int SW = $clog2(CYCLE_CYC + 2) + 1;

  logic          cv_d, sck_d;
  logic [7:0]    rise_cnt;
  logic [SW-1:0] since_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cv_d       <= 1'b0;
      sck_d      <= 1'b0;
      rise_cnt   <= '0;
      since_rise <= '1;
    end else begin
      cv_d  <= convst_o;
      sck_d <= sck_o;
      if (convst_o && !cv_d)      rise_cnt <= '0;
      else if (sck_o && !sck_d)   rise_cnt <= rise_cnt + 8'd1;
      if (convst_o && !cv_d)      since_rise <= SW'(1);
      else if (since_rise != '1)  since_rise <= since_rise + SW'(1);
    end
  end

  // R2
  p_busy_with_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(convst_o) |-> busy_o && !$past(busy_o));
  // R5
  p_sck_only_reading_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sck_o |-> busy_o && !convst_o);
  // R5
  p_twelve_rises_r5: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> rise_cnt == 8'(BITS));
  // R6
  p_sdi_moves_on_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sdi_o) |-> $fell(sck_o) || $past(serial_go));
  // R8
  p_negative_needs_msb_r8: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o && negative_o |-> sample_msb);
  // R9
  p_valid_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |=> !valid_o);
  // R9
  p_busy_ends_at_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> valid_o);
  // R10
  p_rate_spacing_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(convst_o) |-> since_rise >= SW'(CYCLE_CYC));
endmodule

bind sar_adc_host sar_adc_host_chk #(
  .CYCLE_CYC (CYCLE_CYC),
  .BITS      (sar_pkg::SAMPLE_W)
) i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .busy_o     (busy_o),
  .valid_o    (valid_o),
  .convst_o   (convst_o),
  .sck_o      (sck_o),
  .sdi_o      (sdi_o),
  .sample_msb (sample_o[sar_pkg::SAMPLE_W-1]),
  .negative_o (negative_o),
  .serial_go  (serial_go)
);

// File: tb/test_sar_adc_host.sv
module test_sar_adc_host;
  localparam int STRB = 2;
  localparam int CONV = 160;
  localparam int ACQ  = 24;
  localparam int CYC  = 200;
  localparam int MODEL_CONV = 155;

  // {value[11:0], single, odd, sel[1:0], uni, sleep, hold}
  localparam logic [18:0] VECS [6] = '{
    {12'hA5C, 1'b1, 1'b0, 2'b00, 1'b1, 1'b0, 1'b0},
    {12'h800, 1'b0, 1'b1, 2'b10, 1'b0, 1'b0, 1'b1},
    {12'h7FF, 1'b1, 1'b1, 2'b11, 1'b0, 1'b1, 1'b0},
    {12'h001, 1'b0, 1'b0, 2'b01, 1'b1, 1'b1, 1'b1},
    {12'hFFF, 1'b1, 1'b0, 2'b10, 1'b0, 1'b0, 1'b0},
    {12'h000, 1'b0, 1'b1, 2'b01, 1'b1, 1'b0, 1'b1}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, c_single = 1'b0, c_odd = 1'b0, c_uni = 1'b0, c_sleep = 1'b0, hold = 1'b0;
  logic [1:0] c_sel = 2'b00;
  logic busy, valid, negative, convst, sck, sdi, sdo;
  logic [11:0] sample;

  int n_chk = 0, n_fail = 0;

  always #5 clk = !clk;

  sar_adc_host i_sar_adc_host (
    .clk(clk), .rst_n(rst_n), .start_i(start), .cfg_single_i(c_single),
    .cfg_odd_i(c_odd), .cfg_sel_i(c_sel), .cfg_uni_i(c_uni), .cfg_sleep_i(c_sleep),
    .hold_high_i(hold), .busy_o(busy), .valid_o(valid), .sample_o(sample),
    .negative_o(negative), .convst_o(convst), .sck_o(sck), .sdi_o(sdi), .sdo_i(sdo)
  );

  // Converter model plus port monitor.
  logic [11:0] adc_val = 12'h000, cur = 12'h000;
  logic [3:0]  bitidx = 4'd11;
  logic [5:0]  cfg_seen = 6'd0;
  logic        cv_p = 1'b0, sck_p = 1'b0;
  int conv_left = 0, elapsed = 0, rises_m = 0, slept = 0, viol = 0;
  int cyc = 0, t_rise = 0, t_prev_rise = -100000, t_fall = 0, t_sck1 = 0;
  int t_valid = -100000, n_sck = 0, n_rise = 0, vlen = 0, vlen_last = 0;

  assign sdo = (conv_left == 0 && !convst) ? cur[bitidx] : 1'b0;

  always @(posedge clk) begin
    cyc   <= cyc + 1;
    cv_p  <= convst;
    sck_p <= sck;
    if (convst && !cv_p && conv_left == 0) begin
      cur <= adc_val; conv_left <= MODEL_CONV; elapsed <= 0; bitidx <= 4'd11;
      cfg_seen <= 6'd0; rises_m <= 0; slept <= 0;
      t_prev_rise <= t_rise; t_rise <= cyc; n_sck <= 0; n_rise <= n_rise + 1;
    end else begin
      elapsed <= elapsed + 1;
      if (conv_left > 0) begin
        conv_left <= conv_left - 1;
        if (conv_left == 1 && convst) slept <= 1;
      end
    end
    if (!convst && cv_p) begin
      t_fall <= cyc;
      if (conv_left > 0 && elapsed > 4) viol <= viol + 1;
    end
    if (sck && !sck_p) begin
      if (rises_m < 6) cfg_seen <= {cfg_seen[4:0], sdi};
      rises_m <= rises_m + 1;
      n_sck   <= n_sck + 1;
      if (n_sck == 0) t_sck1 <= cyc;
    end
    if (!sck && sck_p && bitidx != 4'd0) bitidx <= bitidx - 4'd1;
    if (valid) begin vlen <= vlen + 1; t_valid <= cyc; end
    else if (vlen != 0) begin vlen_last <= vlen; vlen <= 0; end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  always @(posedge clk) if (cyc > 150000) begin
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: idle outputs under reset
    check(!convst && !sck && !sdi, "R1", {convst, sck, sdi}, 0);
    check(!busy && !valid, "R1", {busy, valid}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < 6; i++) begin
      logic [18:0] v;
      logic [5:0]  exp_cfg;
      int prev_valid, rises_before, w;
      v = VECS[i];
      adc_val = v[18:7];
      {c_single, c_odd, c_sel, c_uni, c_sleep, hold} = v[6:0];
      exp_cfg = v[6:1];
      prev_valid = t_valid;
      rises_before = n_rise;
      start = 1'b1;
      w = 0;
      do begin @(negedge clk); w++; end while (!busy && w < 400);
      // R2: strobe and busy together
      check(busy && convst, "R2", {busy, convst}, 3);
      // R2: vector 2 keeps requesting during the whole conversion
      if (i != 2) start = 1'b0;
      w = 0;
      while (!valid && w < 2000) begin @(negedge clk); w++; end
      start = 1'b0;
      check(n_rise - rises_before == 1, "R2", n_rise - rises_before, 1);
      check(!busy, "R9", busy, 0);
      check(sample == adc_val, "R7", sample, adc_val);
      check(negative == (!v[2] && adc_val[11]), "R8", negative, !v[2] && adc_val[11]);
      repeat (2) @(negedge clk);
      check(vlen_last == 1, "R9", vlen_last, 1);
      check(cfg_seen == exp_cfg, "R6", cfg_seen, exp_cfg);
      check(n_sck == 12, "R5", n_sck, 12);
      check(t_sck1 - t_rise >= CONV, "R5", t_sck1 - t_rise, CONV);
      if (v[0]) begin
        check(t_fall - t_rise == CONV, "R4", t_fall - t_rise, CONV);
        check(slept == 1, "R4", slept, 1);
      end else begin
        check(t_fall - t_rise == STRB, "R3", t_fall - t_rise, STRB);
        check(slept == 0, "R3", slept, 0);
      end
      check(viol == 0, "R3", viol, 0);
      if (i > 0) begin
        check(t_rise - prev_valid >= ACQ, "R10", t_rise - prev_valid, ACQ);
        check(t_rise - t_prev_rise >= CYC, "R10", t_rise - t_prev_rise, CYC);
      end
    end

    // R6: data line back low after the readout
    check(!sdi && !sck, "R6", {sdi, sck}, 0);
    // R1: reset mid-conversion returns outputs to idle
    start = 1'b1;
    repeat (5) @(negedge clk);
    start = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    check(!convst && !busy && !valid, "R1", {convst, busy, valid}, 0);
    finish_run();
  end
endmodule